// File: doc/BRIEF.md
# Processor Low-Power Mode Sequencer

This block decides when a processor core may stop its functional-unit clocks, power down its cache and halt its clock synthesizer, and how it comes back. Software asks for one of four sleep depths while the core is running. Each depth gates a different set of resources and accepts its own set of wake events. Each depth also costs its own number of cycles to resume. The deeper the mode, the more it switches off and the longer the core waits before it may execute again.

The sequencer raises the enables on the way back in a fixed order. The clock synthesizer enable comes first, the cache enable second, and the unit clocks last, together with the ready flag. The lock time of the clock synthesizer is modelled as a plain counted delay. For the deepest mode that delay stands for roughly 100 µs and is set by a parameter. All outputs come from registers. The block drives enable levels only; it contains no clock gating cells.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, the block is in run mode: `mode_out`=0, `ready`=1, and `unit_clk_en`, `cache_en` and `pll_en` are all 1.
- R2: In run mode, `req_valid` with `req_mode` set to 1 (doze), 2 (nap), 3 (sleep) or 4 (clock-off sleep) makes the block enter that mode on the next edge, with `mode_out` equal to the code and `ready` at 0. The codes 0, 5, 6 and 7 have no effect.
- R3: Each mode holds its own enables. Doze has units off, cache on and PLL on. Nap has units off, cache off and PLL on. Sleep and clock-off sleep have all three off.
- R4: `req_valid` has no effect while the block is in a sleep mode or resuming.
- R5: In doze and nap, either `timeout_in` or `ext_irq` starts the resume.
- R6: In sleep and clock-off sleep, `timeout_in` is ignored and only `ext_irq` starts the resume.
- R7: The wake latency L is counted from the edge that samples the wake event, E. `ready` returns at edge E+L. L is 3 for doze, 5 for nap, 10 for sleep, and 200 for clock-off sleep (the 200 is a parameter standing for about 100 µs).
- R8: On resume, `pll_en` rises at E and `cache_en` rises at E+L-1 (it stays on throughout in doze). At E+L, `unit_clk_en` and `ready` rise and `mode_out` returns to 0, all together.
- R9: Wake events that arrive during a resume neither restart nor shorten the latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Software mode request strobe |
| req_mode | input | 3 | Requested mode code (1..4 valid) |
| timeout_in | input | 1 | Timer expiry wake event |
| ext_irq | input | 1 | External interrupt wake event |
| unit_clk_en | output | 1 | Functional-unit clock enable |
| cache_en | output | 1 | Cache power enable |
| pll_en | output | 1 | Clock synthesizer enable |
| mode_out | output | 3 | Current mode code, 0 when running |
| ready | output | 1 | Core may execute |

## Verification
A wrongly decoded mode shows in the very next cycle as a wrong enable triple or a wrong `mode_out` at entry. A latency counter that is loaded wrongly, or that restarts, moves the rise of `ready` and `unit_clk_en` away from edge E+L, so it is visible at the end of one resume. An inverted wake qualification shows either as a resume from sleep on a timeout pulse, which lifts `pll_en` one cycle after the pulse, or as a doze or nap that never leaves. The order of the enables is checked on every resume, cycle by cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_DOZE  = 3'd1,
    PM_NAP   = 3'd2,
    PM_SLEEP = 3'd3,
    PM_OFF   = 3'd4
  } pm_mode_e;

  typedef struct packed {
    logic unit;
    logic cache;
    logic pll;
  } pm_gate_t;

  function automatic logic is_sleep_code(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

  function automatic pm_gate_t gate_profile(input pm_mode_e m);
    pm_gate_t g;
    case (m)
      PM_DOZE: g = '{unit: 1'b0, cache: 1'b1, pll: 1'b1};
      PM_NAP:  g = '{unit: 1'b0, cache: 1'b0, pll: 1'b1};
      PM_SLEEP,
      PM_OFF:  g = '{unit: 1'b0, cache: 1'b0, pll: 1'b0};
      default: g = '{unit: 1'b1, cache: 1'b1, pll: 1'b1};
    endcase
    return g;
  endfunction

  function automatic logic timer_may_wake(input pm_mode_e m);
    return (m == PM_DOZE) || (m == PM_NAP);
  endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_mode_pkg::*;
(
  input  logic     asleep,
  input  pm_mode_e mode,
  input  logic     timeout_in,
  input  logic     ext_irq,
  output logic     wake
);
  always_comb begin
    wake = asleep && (ext_irq || (timeout_in && timer_may_wake(mode)));
  end
endmodule

// File: rtl/pwr_lat_sel.sv
module pwr_lat_sel
  import pwr_mode_pkg::*;
#(
  parameter int DOZE_LAT  = 3,
  parameter int NAP_LAT   = 5,
  parameter int SLEEP_LAT = 10,
  parameter int OFF_LAT   = 200,
  parameter int LAT_W     = 8
) (
  input  pm_mode_e         mode,
  output logic [LAT_W-1:0] lat_m1
);
  always_comb begin
    case (mode)
      PM_DOZE:  lat_m1 = LAT_W'(DOZE_LAT - 1);
      PM_NAP:   lat_m1 = LAT_W'(NAP_LAT - 1);
      PM_SLEEP: lat_m1 = LAT_W'(SLEEP_LAT - 1);
      PM_OFF:   lat_m1 = LAT_W'(OFF_LAT - 1);
      default:  lat_m1 = '0;
    endcase
  end
endmodule

// File: rtl/pwr_resume_timer.sv
module pwr_resume_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             cache_stage,
  output logic             done
);
  logic [LAT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign cache_stage = busy && (cnt == LAT_W'(1));
  assign done        = busy && (cnt == '0);
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int DOZE_LAT  = 3,
  parameter int NAP_LAT   = 5,
  parameter int SLEEP_LAT = 10,
  parameter int OFF_LAT   = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       timeout_in,
  input  logic       ext_irq,
  output logic       unit_clk_en,
  output logic       cache_en,
  output logic       pll_en,
  output logic [2:0] mode_out,
  output logic       ready
);
  localparam int MAX_A = (DOZE_LAT > NAP_LAT) ? DOZE_LAT : NAP_LAT;
  localparam int MAX_B = (SLEEP_LAT > OFF_LAT) ? SLEEP_LAT : OFF_LAT;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int LAT_W = $clog2(MAX_LAT + 1);

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAKE} st_e;

  st_e              st;
  pm_mode_e         mode_q;
  logic             wake;
  logic [LAT_W-1:0] lat_m1;
  logic             t_cache;
  logic             t_done;
  pm_gate_t         entry_gate;

  assign entry_gate = gate_profile(pm_mode_e'(req_mode));

  pwr_wake_qual u_wake (
    .asleep     (st == ST_SLEEP),
    .mode       (mode_q),
    .timeout_in (timeout_in),
    .ext_irq    (ext_irq),
    .wake       (wake)
  );

  pwr_lat_sel #(
    .DOZE_LAT (DOZE_LAT),
    .NAP_LAT  (NAP_LAT),
    .SLEEP_LAT(SLEEP_LAT),
    .OFF_LAT  (OFF_LAT),
    .LAT_W    (LAT_W)
  ) u_lat (
    .mode   (mode_q),
    .lat_m1 (lat_m1)
  );

  pwr_resume_timer #(.LAT_W(LAT_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .load        (wake),
    .load_val    (lat_m1),
    .cache_stage (t_cache),
    .done        (t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      mode_q      <= PM_RUN;
      unit_clk_en <= 1'b1;
      cache_en    <= 1'b1;
      pll_en      <= 1'b1;
      ready       <= 1'b1;
    end else begin
      case (st)
        ST_RUN: begin
          if (req_valid && is_sleep_code(req_mode)) begin
            st          <= ST_SLEEP;
            mode_q      <= pm_mode_e'(req_mode);
            unit_clk_en <= entry_gate.unit;
            cache_en    <= entry_gate.cache;
            pll_en      <= entry_gate.pll;
            ready       <= 1'b0;
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            st     <= ST_WAKE;
            pll_en <= 1'b1;
          end
        end
        ST_WAKE: begin
          if (t_cache) cache_en <= 1'b1;
          if (t_done) begin
            st          <= ST_RUN;
            mode_q      <= PM_RUN;
            unit_clk_en <= 1'b1;
            cache_en    <= 1'b1;
            ready       <= 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign mode_out = mode_q;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_mode,
  input logic       timeout_in,
  input logic       ext_irq,
  input logic       unit_clk_en,
  input logic       cache_en,
  input logic       pll_en,
  input logic [2:0] mode_out,
  input logic       ready
);
  a_r1_reset_run: assert property (@(posedge clk)
    rst |=> (mode_out == 3'd0 && ready && unit_clk_en && cache_en && pll_en));

  a_r2_enter_mode: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && req_mode >= 3'd1 && req_mode <= 3'd4)
      |=> (!ready && mode_out == $past(req_mode)));

  a_r3_units_off_asleep: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !unit_clk_en);

  a_r3_doze_cache_kept: assert property (@(posedge clk) disable iff (rst)
    (mode_out == 3'd1) |-> (cache_en && pll_en));

  a_r4_no_req_asleep: assert property (@(posedge clk) disable iff (rst)
    (!ready && !pll_en && req_valid && !ext_irq) |=> (mode_out == $past(mode_out)));

  a_r5_nap_timeout_wakes: assert property (@(posedge clk) disable iff (rst)
    (mode_out == 3'd2 && !cache_en && !ready && timeout_in && $stable(mode_out)) |=> pll_en);

  a_r6_timeout_ignored: assert property (@(posedge clk) disable iff (rst)
    ((mode_out == 3'd3 || mode_out == 3'd4) && !pll_en && timeout_in && !ext_irq) |=> !pll_en);

  a_r8_cache_needs_pll: assert property (@(posedge clk) disable iff (rst)
    cache_en |-> pll_en);

  a_r8_units_need_cache: assert property (@(posedge clk) disable iff (rst)
    unit_clk_en |-> cache_en);

  a_r8_return_together: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($rose(unit_clk_en) && mode_out == 3'd0));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .timeout_in (timeout_in),
  .ext_irq    (ext_irq),
  .unit_clk_en(unit_clk_en),
  .cache_en   (cache_en),
  .pll_en     (pll_en),
  .mode_out   (mode_out),
  .ready      (ready)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_DOZE  = 3;
  localparam int LAT_NAP   = 5;
  localparam int LAT_SLEEP = 10;
  localparam int LAT_OFF   = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_mode = 3'd0;
  logic       timeout_in = 1'b0;
  logic       ext_irq = 1'b0;
  logic       unit_clk_en, cache_en, pll_en, ready;
  logic [2:0] mode_out;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct packed {
    int         at;
    logic       u;
    logic       c;
    logic       p;
    logic [2:0] m;
    logic       r;
    int         rq;
  } exp_t;

  exp_t sb[$];
  exp_t e;

  pwr_mode_ctl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .timeout_in(timeout_in), .ext_irq(ext_irq), .unit_clk_en(unit_clk_en),
    .cache_en(cache_en), .pll_en(pll_en), .mode_out(mode_out), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare at the falling edge after the expected rising edge
  always @(negedge clk) begin
    while (sb.size() != 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      total++;
      if (e.at != cyc || unit_clk_en !== e.u || cache_en !== e.c || pll_en !== e.p ||
          mode_out !== e.m || ready !== e.r) begin
        bad++;
        $display("FAIL R%0d cyc=%0d(exp %0d) got u=%b c=%b p=%b m=%0d r=%b exp u=%b c=%b p=%b m=%0d r=%b",
                 e.rq, cyc, e.at, unit_clk_en, cache_en, pll_en, mode_out, ready,
                 e.u, e.c, e.p, e.m, e.r);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int at, logic u, logic c, logic p, logic [2:0] m, logic r, int rq);
    exp_t x;
    x.at = at; x.u = u; x.c = c; x.p = p; x.m = m; x.r = r; x.rq = rq;
    sb.push_back(x);
  endtask

  function automatic int lat_of(logic [2:0] m);
    case (m)
      3'd1: return LAT_DOZE;
      3'd2: return LAT_NAP;
      3'd3: return LAT_SLEEP;
      default: return LAT_OFF;
    endcase
  endfunction

  task automatic push_asleep(int at, logic [2:0] m, int rq);
    // R3: doze u0 c1 p1, nap u0 c0 p1, sleep/off u0 c0 p0
    push(at, 1'b0, (m == 3'd1), (m <= 3'd2), m, 1'b0, rq);
  endtask

  task automatic push_run(int at, int rq);
    push(at, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, rq);
  endtask

  task automatic request(logic [2:0] m, int rq);
    req_valid = 1'b1;
    req_mode  = m;
    tick();
    req_valid = 1'b0;
    req_mode  = 3'd0;
    if (m >= 3'd1 && m <= 3'd4) push_asleep(cyc, m, rq);
    else push_run(cyc, rq);
  endtask

  // src: 0 timeout, 1 irq. noise: 0 none, 1 extra irq+timeout, 2 request
  task automatic wake(logic [2:0] m, int src, int noise);
    int lat = lat_of(m);
    int ev;
    if (src == 0) timeout_in = 1'b1; else ext_irq = 1'b1;
    tick();
    timeout_in = 1'b0;
    ext_irq    = 1'b0;
    ev = cyc;
    push(ev, 1'b0, (m == 3'd1), 1'b1, m, 1'b0, 8);          // R8 pll first
    if (lat >= 3) push(ev + 1, 1'b0, (m == 3'd1), 1'b1, m, 1'b0, 8);
    push(ev + lat - 1, 1'b0, 1'b1, 1'b1, m, 1'b0, 8);       // R8 cache next
    push_run(ev + lat, 7);                                  // R7 latency
    for (int i = 0; i < lat; i++) begin
      if (i == 0 && noise == 1) begin ext_irq = 1'b1; timeout_in = 1'b1; end   // R9
      if (i == 0 && noise == 2) begin req_valid = 1'b1; req_mode = 3'd3; end   // R4
      tick();
      ext_irq = 1'b0; timeout_in = 1'b0; req_valid = 1'b0; req_mode = 3'd0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired at cyc=%0d exp finish", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    push_run(cyc, 1);                       // R1 during reset
    rst = 1'b0;
    tick();
    push_run(cyc, 1);                       // R1 first edge after reset

    request(3'd0, 2);                       // R2 invalid codes ignored
    request(3'd5, 2);
    request(3'd7, 2);

    // doze, woken by timeout then by irq (R5)
    request(3'd1, 2);
    tick(); push_asleep(cyc, 3'd1, 3);      // R3 holds
    wake(3'd1, 0, 0);
    request(3'd1, 2);
    wake(3'd1, 1, 0);

    // nap: request ignored while asleep (R4), woken by timeout (R5)
    request(3'd2, 2);
    req_valid = 1'b1; req_mode = 3'd4;
    tick();
    req_valid = 1'b0; req_mode = 3'd0;
    push_asleep(cyc, 3'd2, 4);              // R4
    wake(3'd2, 0, 2);                       // R4 request during resume

    // sleep: timeout ignored (R6), irq wakes, noise during resume (R9)
    request(3'd3, 2);
    timeout_in = 1'b1;
    tick();
    timeout_in = 1'b0;
    push_asleep(cyc, 3'd3, 6);              // R6
    tick(); tick();
    push_asleep(cyc, 3'd3, 6);              // R6
    wake(3'd3, 1, 1);

    // clock-off sleep: timeout ignored (R6), long latency (R7)
    request(3'd4, 2);
    timeout_in = 1'b1;
    tick();
    tick();
    timeout_in = 1'b0;
    push_asleep(cyc, 3'd4, 6);              // R6
    wake(3'd4, 1, 1);                       // R9 noise at start of resume

    request(3'd0, 2);                       // still running afterwards
    tick(); tick();
    if (sb.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R7 unconsumed expectations=%0d exp 0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule